// File: doc/BRIEF.md
# Sub-word Data Memory Port

This block is the data-side memory of a small 32-bit processor. It takes a base register value and a signed 16-bit displacement, forms the effective byte address, and uses it to read a whole word or to write a byte, a halfword or a word. Storage is a byte-lane RAM of 32-bit words whose depth is a parameter. Writes drive one strobe per byte lane, and each lane is a separate array so that block RAM can be inferred.

Reads are registered. The word read at a clock edge, together with the byte offset and the load kind, is held in registers. A formatting stage then picks the addressed byte or halfword and extends it to 32 bits with its sign or with zeros. Bytes are numbered big-endian inside a word. Requests whose address does not suit their access size are refused and reported on an error output.

Top module: `dmem_port`

## Requirements
- R1: The effective address is `base + sign_extend(ofs)` taken modulo 2^32. Only bits [AW+1:0] of it are used (AW = log2 DEPTH), so addresses that differ only in higher bits reach the same byte.
- R2: The `op` code selects the access: 0 word read, 1 byte write, 2 halfword write, 3 word write. An enabled, aligned write updates storage at the rising clock edge. A read changes no stored byte.
- R3: Byte order is big-endian: byte offset 0 is bits 31:24 and offset 3 is bits 7:0. A byte write stores `wdata[7:0]` into the addressed lane only, and the other three bytes of the word keep their values.
- R4: A halfword write stores `wdata[15:0]`. Offset 0 writes bits 31:16 of the word and offset 2 writes bits 15:0.
- R5: `ld_kind` encodes the loads: 0 word, 1 signed byte, 2 unsigned byte, 3 signed halfword, 4 unsigned halfword. Codes 5 to 7 act as a word load. The result of an accepted read appears on `rdata` one clock after the request. `rdata` holds its value until the next accepted read.
- R6: The signed loads copy bit 7 (byte) or bit 15 (halfword) of the selected data into all upper bits. The unsigned loads fill the upper bits with zeros.
- R7: A word access needs address bits [1:0] = 0 and a halfword access needs bit 0 = 0. For writes the size comes from `op`, and for reads it comes from `ld_kind`. A misaligned request writes nothing and leaves `rdata` unchanged. It raises `align_err` for the one cycle after it.
- R8: While `en` is low nothing is read or written, `rdata` holds and `align_err` stays low.
- R9: Synchronous reset drives `rdata` and `align_err` to 0. Stored bytes are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Request enable |
| op | input | 2 | Access code (R2) |
| ld_kind | input | 3 | Load kind for reads (R5) |
| base | input | 32 | Base register value |
| ofs | input | 16 | Signed displacement |
| wdata | input | 32 | Write data, low bits used for sub-word writes |
| rdata | output | 32 | Formatted load result |
| align_err | output | 1 | Misaligned request seen in the previous cycle |

## Verification
The hardest case to reach is a refused request that sits right next to valid data. A misaligned write must leave all four bytes of the word unchanged, and a misaligned read must keep the previous result on `rdata`. The bench fills memory with a pattern it knows. It then tries every misaligned offset in every word for each access size, and reads the word back with an aligned word load to show that nothing was disturbed. Aliased bases and negative displacements are mixed into the sweeps so that the address adder and the truncated index are exercised too.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    OP_RD_WORD = 2'd0,
    OP_WR_BYTE = 2'd1,
    OP_WR_HALF = 2'd2,
    OP_WR_WORD = 2'd3
  } op_e;

  localparam logic [2:0] LK_WORD = 3'd0;
  localparam logic [2:0] LK_SB   = 3'd1;
  localparam logic [2:0] LK_UB   = 3'd2;
  localparam logic [2:0] LK_SH   = 3'd3;
  localparam logic [2:0] LK_UH   = 3'd4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

endpackage

// File: rtl/dmem_agu.sv
module dmem_agu
  import dmem_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFSW = 16
) (
  input  logic [XLEN-1:0] base,
  input  logic [OFSW-1:0] ofs,
  input  logic [1:0]      op,
  input  logic [2:0]      ld_kind,
  output logic [XLEN-1:0] ea,
  output logic            misaligned
);

  size_e size;

  assign ea = base + {{(XLEN-OFSW){ofs[OFSW-1]}}, ofs};

  always_comb begin
    unique case (op)
      OP_WR_BYTE: size = SZ_BYTE;
      OP_WR_HALF: size = SZ_HALF;
      OP_WR_WORD: size = SZ_WORD;
      default: begin
        if (ld_kind == LK_SB || ld_kind == LK_UB)      size = SZ_BYTE;
        else if (ld_kind == LK_SH || ld_kind == LK_UH) size = SZ_HALF;
        else                                           size = SZ_WORD;
      end
    endcase
  end

  always_comb begin
    unique case (size)
      SZ_WORD: misaligned = (ea[1:0] != 2'b00);
      SZ_HALF: misaligned = ea[0];
      default: misaligned = 1'b0;
    endcase
  end

endmodule

// File: rtl/dmem_strobe.sv
module dmem_strobe
  import dmem_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic          en,
  input  logic [1:0]    op,
  input  logic          misaligned,
  input  logic [1:0]    boff,
  input  logic [DW-1:0] wdata,
  output logic [LANES-1:0] lane_we,
  output logic [DW-1:0] lane_wd
);

  logic [LANES-1:0] mask;

  always_comb begin
    unique case (op)
      OP_WR_BYTE: mask = 4'b1000 >> boff;
      OP_WR_HALF: mask = boff[1] ? 4'b0011 : 4'b1100;
      OP_WR_WORD: mask = 4'b1111;
      default:    mask = 4'b0000;
    endcase
  end

  assign lane_we = (en && !misaligned) ? mask : '0;

  always_comb begin
    unique case (op)
      OP_WR_BYTE: lane_wd = {4{wdata[7:0]}};
      OP_WR_HALF: lane_wd = {2{wdata[15:0]}};
      default:    lane_wd = wdata;
    endcase
  end

endmodule

// File: rtl/dmem_lane_ram.sv
module dmem_lane_ram #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    idx,
  input  logic [LANES-1:0] lane_we,
  input  logic [DW-1:0]    lane_wd,
  input  logic             rd_en,
  output logic [DW-1:0]    q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[idx] <= lane_wd[8*g +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst)        q[8*g +: 8] <= 8'h00;
      else if (rd_en) q[8*g +: 8] <= mem[idx];
    end
  end

endmodule

// File: rtl/dmem_load_fmt.sv
module dmem_load_fmt
  import dmem_pkg::*;
(
  input  logic [31:0] word,
  input  logic [2:0]  ld_kind,
  input  logic [1:0]  boff,
  output logic [31:0] data
);

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    unique case (boff)
      2'd0: sel_b = word[31:24];
      2'd1: sel_b = word[23:16];
      2'd2: sel_b = word[15:8];
      default: sel_b = word[7:0];
    endcase
  end

  assign sel_h = boff[1] ? word[15:0] : word[31:16];

  always_comb begin
    if (ld_kind == LK_SB)      data = {{24{sel_b[7]}}, sel_b};
    else if (ld_kind == LK_UB) data = {24'h0, sel_b};
    else if (ld_kind == LK_SH) data = {{16{sel_h[15]}}, sel_h};
    else if (ld_kind == LK_UH) data = {16'h0, sel_h};
    else                       data = word;
  end

endmodule

// File: rtl/dmem_port.sv
module dmem_port
  import dmem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [1:0]  op,
  input  logic [2:0]  ld_kind,
  input  logic [31:0] base,
  input  logic [15:0] ofs,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        align_err
);

  logic [31:0] ea;
  logic        misaligned;
  logic [3:0]  lane_we;
  logic [31:0] lane_wd;
  logic [31:0] ram_q;
  logic        rd_fire;
  logic [2:0]  kind_q;
  logic [1:0]  boff_q;
  logic        err_q;
  logic        unused_hi;

  assign unused_hi = ^ea[31:AW+2];

  dmem_agu #(.XLEN(32), .OFSW(16)) u_agu (
    .base(base), .ofs(ofs), .op(op), .ld_kind(ld_kind),
    .ea(ea), .misaligned(misaligned)
  );

  dmem_strobe #(.LANES(4)) u_strobe (
    .en(en), .op(op), .misaligned(misaligned), .boff(ea[1:0]),
    .wdata(wdata), .lane_we(lane_we), .lane_wd(lane_wd)
  );

  assign rd_fire = en && (op == OP_RD_WORD) && !misaligned;

  dmem_lane_ram #(.DEPTH(DEPTH), .LANES(4)) u_ram (
    .clk(clk), .rst(rst), .idx(ea[AW+1:2]), .lane_we(lane_we),
    .lane_wd(lane_wd), .rd_en(rd_fire), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= LK_WORD;
      boff_q <= 2'd0;
      err_q  <= 1'b0;
    end else begin
      err_q <= en && misaligned;
      if (rd_fire) begin
        kind_q <= ld_kind;
        boff_q <= ea[1:0];
      end
    end
  end

  dmem_load_fmt u_fmt (
    .word(ram_q), .ld_kind(kind_q), .boff(boff_q), .data(rdata)
  );

  assign align_err = err_q;

  p_err_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    align_err |-> $past(en));

  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !en |-> (lane_we == 4'b0000));

  p_mis_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (lane_we == 4'b0000));

  p_read_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_WORD) |-> (lane_we == 4'b0000));

  p_strobe_shape_r2: assert property (@(posedge clk) disable iff (rst)
    (lane_we != 4'b0000) |-> ($countones(lane_we) == 1 ||
                              $countones(lane_we) == 2 ||
                              $countones(lane_we) == 4));

  p_hold_rdata_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !rd_fire) |-> $stable(rdata));

endmodule

// File: tb/dmem_port_tb.sv
`timescale 1ns/1ps
module dmem_port_tb;

  localparam int DEPTH = 16;
  localparam int NB = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [2:0]  ld_kind = 3'd0;
  logic [31:0] base = 32'h0;
  logic [15:0] ofs = 16'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        align_err;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [NB];
  logic [31:0] last_rd;

  always #2.5 clk = ~clk;

  dmem_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .ld_kind(ld_kind),
    .base(base), .ofs(ofs), .wdata(wdata), .rdata(rdata), .align_err(align_err)
  );

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic int eaddr(input logic [31:0] b, input logic [15:0] o);
    logic [31:0] s;
    s = b + {{16{o[15]}}, o};
    return int'(s[5:0]);
  endfunction

  function automatic logic [31:0] mword(input int a);
    int w;
    w = a & ~3;
    return {model[w], model[w+1], model[w+2], model[w+3]};
  endfunction

  function automatic logic [31:0] exp_load(input logic [2:0] k, input int a);
    logic [15:0] h;
    h = {model[a & ~1], model[(a & ~1) + 1]};
    case (k)
      3'd1: return {{24{model[a][7]}}, model[a]};
      3'd2: return {24'h0, model[a]};
      3'd3: return {{16{h[15]}}, h};
      3'd4: return {16'h0, h};
      default: return mword(a);
    endcase
  endfunction

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic op_go(input logic [1:0] c, input logic [2:0] k, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] wd, input bit e);
    int a;
    bit mis;
    a = eaddr(b, o);
    case (c)
      2'd1: mis = 1'b0;
      2'd2: mis = (a % 2) != 0;
      2'd3: mis = (a % 4) != 0;
      default: mis = (k == 3'd1 || k == 3'd2) ? 1'b0 :
                     (k == 3'd3 || k == 3'd4) ? ((a % 2) != 0) : ((a % 4) != 0);
    endcase
    @(negedge clk);
    en = e; op = c; ld_kind = k; base = b; ofs = o; wdata = wd;
    @(negedge clk);
    en = 1'b0;
    if (e && !mis) begin
      case (c)
        2'd1: model[a] = wd[7:0];
        2'd2: begin model[a] = wd[15:8]; model[a+1] = wd[7:0]; end
        2'd3: begin
          model[a] = wd[31:24]; model[a+1] = wd[23:16];
          model[a+2] = wd[15:8]; model[a+3] = wd[7:0];
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset rdata", rdata, 32'h0);
    check("R9 reset align_err", {31'h0, align_err}, 32'h0);

    // R2 R5 R1: word writes, then word reads through aliased bases
    for (int i = 0; i < DEPTH; i++)
      op_go(2'd3, 3'd0, i * 4, 16'h0, 32'h8000_0001 ^ (i * 32'h1111_1110), 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      op_go(2'd0, 3'd0, i * 4 + 32'h40 * (i % 3) + 32'h1000, 16'h0, 32'h0, 1'b1);
      check("R2 R5 R1 word load", rdata, mword(i * 4));
      check("R7 aligned no err", {31'h0, align_err}, 32'h0);
    end

    // R3 R1: byte writes with a negative displacement, upper wdata bits are junk
    for (int a = 0; a < NB; a++)
      op_go(2'd1, 3'd0, a + 200, 16'hFF38, {24'hABCDEF, 8'(a * 37 + 11)}, 1'b1);
    for (int a = 0; a < NB; a++) begin
      op_go(2'd0, 3'd1, a, 16'h0, 32'h0, 1'b1);
      check("R6 R3 signed byte", rdata, exp_load(3'd1, a));
      op_go(2'd0, 3'd2, a + 32'h4000_0000, 16'h0, 32'h0, 1'b1);
      check("R6 R3 R1 unsigned byte", rdata, exp_load(3'd2, a));
    end
    for (int i = 0; i < DEPTH; i++) begin
      op_go(2'd0, 3'd0, i * 4, 16'h0, 32'h0, 1'b1);
      check("R3 big-endian word", rdata, mword(i * 4));
    end

    // R4 R6: halfword writes and loads
    for (int a = 0; a < NB; a += 2)
      op_go(2'd2, 3'd0, a, 16'h0, {16'hDEAD, 16'(a * 1234 + 77)}, 1'b1);
    for (int a = 0; a < NB; a += 2) begin
      op_go(2'd0, 3'd3, a, 16'h0, 32'h0, 1'b1);
      check("R6 R4 signed half", rdata, exp_load(3'd3, a));
      op_go(2'd0, 3'd4, a, 16'h0, 32'h0, 1'b1);
      check("R6 R4 unsigned half", rdata, exp_load(3'd4, a));
    end
    for (int i = 0; i < DEPTH; i++) begin
      op_go(2'd0, 3'd0, i * 4, 16'h0, 32'h0, 1'b1);
      check("R4 half placement", rdata, mword(i * 4));
    end

    // R7: misaligned requests are refused
    for (int a = 0; a < NB; a++) begin
      if (a % 4 != 0) begin
        op_go(2'd3, 3'd0, a, 16'h0, 32'h1234_5678, 1'b1);
        check("R7 word write err", {31'h0, align_err}, 32'h1);
        op_go(2'd0, 3'd0, a & ~3, 16'h0, 32'h0, 1'b1);
        check("R7 word write suppressed", rdata, mword(a));
        last_rd = rdata;
        op_go(2'd0, 3'd0, a, 16'h0, 32'h0, 1'b1);
        check("R7 word read err", {31'h0, align_err}, 32'h1);
        check("R7 word read holds rdata", rdata, last_rd);
      end
      if (a % 2 != 0) begin
        op_go(2'd2, 3'd0, a, 16'h0, 32'h0000_9ABC, 1'b1);
        check("R7 half write err", {31'h0, align_err}, 32'h1);
        op_go(2'd0, 3'd0, a & ~3, 16'h0, 32'h0, 1'b1);
        check("R7 half write suppressed", rdata, mword(a));
        last_rd = rdata;
        op_go(2'd0, 3'd3, a, 16'h0, 32'h0, 1'b1);
        check("R7 half read err", {31'h0, align_err}, 32'h1);
        check("R7 half read holds rdata", rdata, last_rd);
        op_go(2'd0, 3'd4, a, 16'h0, 32'h0, 1'b1);
        check("R7 uhalf read err", {31'h0, align_err}, 32'h1);
      end
    end

    // R8: disabled requests do nothing
    op_go(2'd0, 3'd0, 32'h8, 16'h0, 32'h0, 1'b1);
    last_rd = rdata;
    op_go(2'd3, 3'd0, 32'h8, 16'h0, 32'hFFFF_FFFF, 1'b0);
    check("R8 idle no err", {31'h0, align_err}, 32'h0);
    check("R8 idle holds rdata", rdata, last_rd);
    op_go(2'd3, 3'd0, 32'h9, 16'h0, 32'hFFFF_FFFF, 1'b0);
    check("R8 idle misaligned no err", {31'h0, align_err}, 32'h0);
    op_go(2'd0, 3'd0, 32'hC, 16'h0, 32'h0, 1'b0);
    check("R8 idle read holds rdata", rdata, last_rd);
    op_go(2'd1, 3'd0, 32'h8, 16'h0, 32'h0, 1'b0);
    op_go(2'd0, 3'd0, 32'h8, 16'h0, 32'h0, 1'b1);
    check("R8 idle write ignored", rdata, mword(8));

    // R5: spare load codes behave as word loads
    for (int k = 5; k < 8; k++) begin
      op_go(2'd0, 3'(k), 32'h14, 16'h0, 32'h0, 1'b1);
      check("R5 spare kind word", rdata, mword(20));
    end

    finish_up();
  end

endmodule